// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command register and control state machine of a byte-wide flash memory. It sits behind a synchronous interface with one-cycle write and read strobes. Host writes are matched against unlock-prefixed command sequences. The recognised sequences are byte program and identification (device ID). A reset command returns the machine to array reads.

A completed program sequence launches the operation on a back-end. The block raises a one-cycle start pulse and holds the target address and data. The back-end ends the operation with a done pulse, which carries a fail flag. The block drives a ready output. It steers each read to one of three sources: array data, identification codes, or a polling status byte.

The unlock addresses, unlock data, command codes and identification codes are all parameters. Only the low `UAW` address bits take part in the unlock match. A hardware reset aborts any operation in progress. Ready then stays low for a short internal reset period.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After the hardware reset input is released, `ready` reads 0 for a few cycles. It then becomes 1 and stays 1. Reads return `array_rdata` without any command being written.
- R2: Four writes in order start a program: 0xAA at low address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then data D at address A. The cycle after the fourth write, `pgm_start` is 1 for exactly one cycle, `pgm_addr`=A, `pgm_data`=D and `ready`=0.
- R3: The identification mode is entered by 0xAA@0x555, 0x55@0x2AA, 0x90@0x555. In this mode, any number of reads at low byte 0x00 return 0x01, and reads at low byte 0x01 return 0xD5.
- R4: In identification mode, a read whose low byte is 0x02 returns 0x01 if the sector in address bits [AW-1:AW-4] is protected (its `prot_bits` bit is 1). Otherwise it returns 0x00.
- R5: A write with the wrong address or data during the unlock or command cycles returns the machine to array reads. The rest of that sequence then starts nothing.
- R6: A write of 0xF0 at any address, made between the cycles of a sequence, aborts the sequence.
- R7: While a program is in progress, all writes are ignored, including 0xF0. `ready` stays 0 until the back-end done pulse arrives.
- R8: Identification mode is left only by a 0xF0 write. Any other write keeps it.
- R9: While a program is in progress, every read returns the status byte. In it, bit 7 is the inverse of bit 7 of the programmed data, bit 6 starts at 0 and inverts on each read, and bit 5 is 0.
- R10: A done pulse with fail=0 returns the machine to array reads with `ready`=1. `pgm_addr` and `pgm_data` both clear to 0.
- R11: A done pulse with fail=1 leaves `ready`=1. Reads keep returning status, with bit 5 set and bit 7 inverted as in R9. Only a 0xF0 write returns the machine to array reads.
- R12: A hardware reset during a program aborts it: `pgm_addr` clears, `ready` is 0 during the internal reset period, and afterwards the machine is in array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | AW | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (array, ID code or status) |
| array_rdata | input | 8 | Array contents at `addr` |
| prot_bits | input | 2**SB | Per-sector protect flags |
| pgm_start | output | 1 | One-cycle program launch pulse |
| pgm_addr | output | AW | Latched program address |
| pgm_data | output | 8 | Latched program data |
| pgm_done | input | 1 | Back-end completion pulse |
| pgm_fail | input | 1 | Failure flag, valid with `pgm_done` |
| ready | output | 1 | 1 when idle, 0 while busy or in reset |

## Verification
The embedded assertions check these rules on every cycle:
- the launch pulse lasts one cycle and coincides with `ready` low;
- a busy operation stays busy until done arrives;
- leaving busy for array reads requires a passing done pulse;
- the identification and failure modes hold against any write other than 0xF0;
- the toggle bit inverts across back-to-back status reads.

Only the directed scenarios can show some behaviours:
- the decoded sequences, including rejection of wrong unlock values and aborts by 0xF0;
- the identification codes and per-sector protect answers;
- clearing of the latched address;
- recovery from a hardware reset during a program.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    ST_RST,
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PSET,
    ST_BUSY,
    ST_FAIL,
    ST_AUTO
  } fcs_state_e;

  localparam int STAT_POLL = 7;
  localparam int STAT_TOG  = 6;
  localparam int STAT_ERR  = 5;
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import fcs_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned UAW = 11,
  parameter logic [UAW-1:0] UNL1_ADDR = 11'h555,
  parameter logic [7:0] UNL1_DATA = 8'hAA,
  parameter logic [UAW-1:0] UNL2_ADDR = 11'h2AA,
  parameter logic [7:0] UNL2_DATA = 8'h55,
  parameter logic [7:0] CMD_PGM = 8'hA0,
  parameter logic [7:0] CMD_AUTO = 8'h90,
  parameter logic [7:0] CMD_RST = 8'hF0,
  parameter int unsigned RST_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          pgm_done,
  input  logic          pgm_fail,
  output fcs_state_e    state_o,
  output logic          pgm_start,
  output logic [AW-1:0] pgm_addr,
  output logic [7:0]    pgm_data,
  output logic          ready
);
  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  fcs_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           start_q, start_d;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic           lat_en, lat_clr;

  logic at_u1, at_u2, is_rst;
  assign at_u1  = (addr[UAW-1:0] == UNL1_ADDR);
  assign at_u2  = (addr[UAW-1:0] == UNL2_ADDR);
  assign is_rst = (wdata == CMD_RST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    lat_en  = 1'b0;
    lat_clr = 1'b0;
    case (state_q)
      ST_RST: begin
        if (cnt_q == '0) state_d = ST_READ;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_READ: begin
        if (wr_en && at_u1 && wdata == UNL1_DATA) state_d = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_en) state_d = (at_u2 && wdata == UNL2_DATA) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (wr_en) begin
          if (at_u1 && wdata == CMD_PGM)       state_d = ST_PSET;
          else if (at_u1 && wdata == CMD_AUTO) state_d = ST_AUTO;
          else                                 state_d = ST_READ;
        end
      end
      ST_PSET: begin
        if (wr_en) begin
          state_d = ST_BUSY;
          start_d = 1'b1;
          lat_en  = 1'b1;
        end
      end
      ST_BUSY: begin
        if (pgm_done) begin
          if (pgm_fail) state_d = ST_FAIL;
          else begin
            state_d = ST_READ;
            lat_clr = 1'b1;
          end
        end
      end
      ST_FAIL: begin
        if (wr_en && is_rst) begin
          state_d = ST_READ;
          lat_clr = 1'b1;
        end
      end
      ST_AUTO: begin
        if (wr_en && is_rst) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RST;
      cnt_q   <= CW'(RST_CYC - 1);
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (lat_en) begin
      addr_q <= addr;
      data_q <= wdata;
    end else if (lat_clr) begin
      addr_q <= '0;
      data_q <= '0;
    end
  end

  assign state_o   = state_q;
  assign pgm_start = start_q;
  assign pgm_addr  = addr_q;
  assign pgm_data  = data_q;
  assign ready     = (state_q != ST_BUSY) && (state_q != ST_RST);

  // R2: launch pulse is a single cycle
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);

  // R2: ready is low while the launch pulse is out
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !ready);

  // R7: busy persists until the back-end reports done
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !pgm_done) |=> (state_q == ST_BUSY));

  // R10: busy exits to array reads only on a passing done pulse
  a_r10_clean_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && $past(state_q) == ST_BUSY) |-> ($past(pgm_done) && !$past(pgm_fail)));

  // R8: identification mode holds against non-reset writes
  a_r8_auto_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AUTO && !(wr_en && is_rst)) |=> (state_q == ST_AUTO));

  // R11: failure state holds against non-reset writes
  a_r11_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL && !(wr_en && is_rst)) |=> (state_q == ST_FAIL));
endmodule

// File: rtl/fcs_rdmux.sv
module fcs_rdmux
  import fcs_pkg::*;
#(
  parameter int unsigned SB = 4,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'hD5,
  localparam int unsigned NSECT = 1 << SB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [SB-1:0]    sect,
  input  logic [7:0]       offs,
  input  fcs_state_e       state_i,
  input  logic             poll_bit,
  input  logic [7:0]       array_rdata,
  input  logic [NSECT-1:0] prot_bits,
  output logic [7:0]       rdata
);
  logic stat_mode;
  logic tog_q, tog_d;

  assign stat_mode = (state_i == ST_BUSY) || (state_i == ST_FAIL);

  always_comb begin
    tog_d = tog_q;
    if (!stat_mode)  tog_d = 1'b0;
    else if (rd_en)  tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  logic [7:0] id_byte;
  always_comb begin
    case (offs)
      8'h00:   id_byte = MFR_CODE;
      8'h01:   id_byte = DEV_CODE;
      8'h02:   id_byte = {7'b0, prot_bits[sect]};
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    case (state_i)
      ST_RST:  rdata = 8'h00;
      ST_AUTO: rdata = id_byte;
      ST_BUSY, ST_FAIL: begin
        rdata[STAT_POLL] = ~poll_bit;
        rdata[STAT_TOG]  = tog_q;
        rdata[STAT_ERR]  = (state_i == ST_FAIL);
      end
      default: rdata = array_rdata;
    endcase
  end

  // R9: back-to-back status reads see the toggle bit invert
  a_r9_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_mode && rd_en && $past(stat_mode && rd_en)) |-> (rdata[STAT_TOG] != $past(rdata[STAT_TOG])));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcs_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned SB = 4,
  parameter int unsigned UAW = 11,
  parameter logic [UAW-1:0] UNL1_ADDR = 11'h555,
  parameter logic [7:0] UNL1_DATA = 8'hAA,
  parameter logic [UAW-1:0] UNL2_ADDR = 11'h2AA,
  parameter logic [7:0] UNL2_DATA = 8'h55,
  parameter logic [7:0] CMD_PGM = 8'hA0,
  parameter logic [7:0] CMD_AUTO = 8'h90,
  parameter logic [7:0] CMD_RST = 8'hF0,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'hD5,
  parameter int unsigned RST_CYC = 4,
  localparam int unsigned NSECT = 1 << SB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [7:0]       array_rdata,
  input  logic [NSECT-1:0] prot_bits,
  output logic             pgm_start,
  output logic [AW-1:0]    pgm_addr,
  output logic [7:0]       pgm_data,
  input  logic             pgm_done,
  input  logic             pgm_fail,
  output logic             ready
);
  logic       rst_n_sync;
  fcs_state_e state;

  fcs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fcs_seq #(
    .AW(AW), .UAW(UAW),
    .UNL1_ADDR(UNL1_ADDR), .UNL1_DATA(UNL1_DATA),
    .UNL2_ADDR(UNL2_ADDR), .UNL2_DATA(UNL2_DATA),
    .CMD_PGM(CMD_PGM), .CMD_AUTO(CMD_AUTO), .CMD_RST(CMD_RST),
    .RST_CYC(RST_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .pgm_done  (pgm_done),
    .pgm_fail  (pgm_fail),
    .state_o   (state),
    .pgm_start (pgm_start),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .ready     (ready)
  );

  fcs_rdmux #(
    .SB(SB), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rd (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .rd_en       (rd_en),
    .sect        (addr[AW-1 -: SB]),
    .offs        (addr[7:0]),
    .state_i     (state),
    .poll_bit    (pgm_data[7]),
    .array_rdata (array_rdata),
    .prot_bits   (prot_bits),
    .rdata       (rdata)
  );
endmodule

// File: tb/sim_flash_cmd_fsm.sv
module sim_flash_cmd_fsm;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [19:0] addr;
  logic [7:0]  wdata, rdata, array_rdata;
  logic [15:0] prot_bits;
  logic        pgm_start, pgm_done, pgm_fail, ready;
  logic [19:0] pgm_addr;
  logic [7:0]  pgm_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  assign array_rdata = addr[7:0] ^ 8'h3C;
  assign prot_bits   = 16'b0000_0000_0010_0100;

  flash_cmd_fsm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .array_rdata(array_rdata), .prot_bits(prot_bits),
    .pgm_start(pgm_start), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .pgm_done(pgm_done), .pgm_fail(pgm_fail), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [19:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic done(input logic f);
    @(negedge clk); pgm_done = 1'b1; pgm_fail = f;
    @(negedge clk); pgm_done = 1'b0; pgm_fail = 1'b0;
    #1;
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (!ready && k < 40) begin @(negedge clk); k++; end
    check(req, {31'b0, ready}, 32'd1);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic start_pgm(input logic [19:0] a, input logic [7:0] d);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'hA0); wr(a, d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    hw_reset();
    check("R1 ready low after reset", {31'b0, ready}, 32'd0);
    wait_ready("R1 ready rises");
    rd(20'h12345, v);
    check("R1 array read", v, 8'h45 ^ 8'h3C);
  endtask

  task automatic t_program();
    logic [7:0] v, v2;
    start_pgm(20'h3A0F1, 8'h5A);
    check("R2 start pulse", pgm_start, 1);
    check("R2 addr", pgm_addr, 20'h3A0F1);
    check("R2 data", pgm_data, 8'h5A);
    check("R2 busy", ready, 0);
    @(negedge clk); #1;
    check("R2 pulse one cycle", pgm_start, 0);
    rd(20'h00000, v);
    rd(20'h00000, v2);
    check("R9 status first", v, 8'h80);
    check("R9 status toggled", v2, 8'hC0);
    wr(20'h00000, 8'hF0);
    check("R7 reset ignored busy", ready, 0);
    wr(20'h00555, 8'hAA);
    rd(20'h00000, v);
    check("R7 still status", v & 8'hA0, 8'h80);
    done(1'b0);
    check("R10 ready", ready, 1);
    check("R10 addr cleared", pgm_addr, 0);
    check("R10 data cleared", pgm_data, 0);
    rd(20'h00077, v);
    check("R10 array read", v, 8'h77 ^ 8'h3C);
  endtask

  task automatic t_auto();
    logic [7:0] v;
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h90);
    rd(20'hABC00, v); check("R3 mfr", v, 8'h01);
    rd(20'h00001, v); check("R3 dev", v, 8'hD5);
    rd(20'h55500, v); check("R3 mfr repeat", v, 8'h01);
    rd(20'h20002, v); check("R4 sector 2 protected", v, 8'h01);
    rd(20'h30002, v); check("R4 sector 3 open", v, 8'h00);
    rd(20'h50002, v); check("R4 sector 5 protected", v, 8'h01);
    wr(20'h00555, 8'hAA); wr(20'h00000, 8'h12);
    rd(20'h00001, v); check("R8 stays in id mode", v, 8'hD5);
    wr(20'h00000, 8'hF0);
    rd(20'h00001, v); check("R8 reset exits", v, 8'h01 ^ 8'h3C);
  endtask

  task automatic t_wrong();
    logic [7:0] v;
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55); wr(20'h00555, 8'hA0); wr(20'h00100, 8'h12);
    check("R5 wrong addr no start", pgm_start, 0);
    check("R5 wrong addr ready", ready, 1);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h54); wr(20'h00555, 8'h90);
    rd(20'h00000, v); check("R5 wrong data array", v, 8'h3C);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00556, 8'h90);
    rd(20'h00001, v); check("R5 wrong cmd addr", v, 8'h01 ^ 8'h3C);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    wr(20'h00555, 8'hAA); wr(20'h00000, 8'hF0);
    wr(20'h002AA, 8'h55); wr(20'h00555, 8'hA0); wr(20'h00044, 8'h33);
    check("R6 abort after unlock1", pgm_start, 0);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00123, 8'hF0);
    wr(20'h00555, 8'h90);
    rd(20'h00000, v); check("R6 abort after unlock2", v, 8'h3C);
  endtask

  task automatic t_fail();
    logic [7:0] v;
    start_pgm(20'h00010, 8'hC3);
    done(1'b1);
    check("R11 ready after fail", ready, 1);
    rd(20'h00010, v); check("R11 status err", v & 8'hA0, 8'h20);
    wr(20'h00555, 8'hAA);
    rd(20'h00010, v); check("R11 fail holds", v & 8'hA0, 8'h20);
    wr(20'h00000, 8'hF0);
    rd(20'h00010, v); check("R11 reset exits", v, 8'h10 ^ 8'h3C);
  endtask

  task automatic t_hwreset();
    logic [7:0] v;
    start_pgm(20'h0F0F0, 8'h11);
    check("R12 busy before reset", ready, 0);
    hw_reset();
    check("R12 ready low in reset", ready, 0);
    check("R12 addr cleared", pgm_addr, 0);
    wait_ready("R12 ready after reset");
    rd(20'h000AB, v); check("R12 array read", v, 8'hAB ^ 8'h3C);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pgm_done = 1'b0; pgm_fail = 1'b0;
    t_reset();
    t_program();
    t_auto();
    t_wrong();
    t_abort();
    t_fail();
    t_hwreset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule